// File: doc/BRIEF.md
# Memory-Backed Register Window Controller

This block serves the operand register file of a processor whose only architectural register is a window base pointer. The 32 operand words of 64 bits each live in memory at consecutive 8-byte addresses starting at the base. The block keeps a shadow copy of the whole window in flip-flops. Two read ports and one write port address it with a 5-bit index, so ordinary operand traffic never reaches memory. Word 0 of the window is the instruction pointer. It has its own output and its own update input, and both are usable on every cycle.

Writing a new base value starts a context swap in hardware. The sequencer first writes the 32 shadow words back to the old window. It then reads the 32 words of the new window into the shadow bank. The memory side is one word-wide request channel. The block holds `mem_valid` high with a stable address, direction and write data until the memory raises `mem_ready` in the same cycle. For reads, `mem_rdata` must be valid in the cycle that `mem_ready` is high. The memory can apply back-pressure for any number of cycles by holding `mem_ready` low. While a swap is running, `busy` is high, all state-changing inputs are ignored and read data is meaningless.

Top module: `regwin_ctrl`

## Requirements
- R1: Reset sets the base to 0 and raises `busy`. The block then makes 32 read transfers from addresses 0, 8, ..., 248 with no write transfer at all, and `busy` falls in the cycle after the last of these reads is acknowledged.
- R2: Operand index n stands for the memory word at byte address base + 8*n. After a load, reading index n returns the word fetched from that address.
- R3: A base write accepted while idle causes exactly 64 transfers in this order: writes of shadow words 0 to 31 to old_base + 8*n, then reads of words 0 to 31 from new_base + 8*n. A transfer completes when `mem_valid` and `mem_ready` are both high. Until then the request holds its address, direction and data.
- R4: The low 3 bits of a written base value are replaced by zero, so every window address is 8-byte aligned.
- R5: `busy` is high from the cycle after an accepted base write until the cycle after the last load is acknowledged. While idle, a base write is accepted in any cycle.
- R6: While `busy` is high, operand writes, instruction-pointer updates and base writes have no effect on the window, on `ip_out` or on `base_out`.
- R7: When a read port selects the index that the write port writes in the same cycle, the read returns the new data. An instruction-pointer update forwards to reads of index 0 in the same way.
- R8: `ip_out` shows window word 0. `ip_we` loads `ip_wdata` into word 0 at the next clock edge, and reads of index 0 then return the new value.
- R9: When the operand write targets index 0 in the same cycle as `ip_we`, the operand write data is stored and the instruction-pointer data is dropped.
- R10: While idle, `mem_valid` stays low, so operand reads and writes never create memory transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_idx | input | 5 | Read port 0 index |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 5 | Read port 1 index |
| rd1_data | output | 64 | Read port 1 data |
| wr_en | input | 1 | Operand write enable |
| wr_idx | input | 5 | Operand write index |
| wr_data | input | 64 | Operand write data |
| ip_out | output | 64 | Current instruction pointer (window word 0) |
| ip_we | input | 1 | Instruction pointer update enable |
| ip_wdata | input | 64 | New instruction pointer value |
| base_we | input | 1 | Base write, starts a swap |
| base_wdata | input | 64 | New base value |
| base_out | output | 64 | Current (aligned) base |
| busy | output | 1 | Swap in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory acknowledge |
| mem_write | output | 1 | Request is a write when high |
| mem_addr | output | 64 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with mem_ready |

## Verification
The bench applies random mixes of operand writes, instruction-pointer updates and paired reads. Some cycles hit the same index or word 0 on several ports at once, which separates the forwarding and priority paths from the plain stored-value path. Swaps run to random bases with unaligned low bits and random memory back-pressure. Every transfer's direction, address and save data is checked against a snapshot of the window, which tells a wrong order, stride or stall from a correct sequence. Junk writes issued during a swap, including a second base write, show that the busy lockout holds. The content of the memory image after each swap confirms that this junk left no trace.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SAVE = 2'd1,
    PH_LOAD = 2'd2
  } phase_t;
endpackage

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int NWORDS = 32,
  parameter int DATA_W = 64,
  parameter int NRD    = 2,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             busy,
  input  logic [NRD-1:0][IDX_W-1:0]        rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]       rd_data,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             ip_we,
  input  logic [DATA_W-1:0]                ip_wdata,
  output logic [DATA_W-1:0]                ip_q,
  input  logic                             ld_en,
  input  logic [IDX_W-1:0]                 ld_idx,
  input  logic [DATA_W-1:0]                ld_data,
  input  logic [IDX_W-1:0]                 sv_idx,
  output logic [DATA_W-1:0]                sv_data
);
  logic [NWORDS-1:0][DATA_W-1:0] words;
  logic usr_we;
  logic ip_take;

  // user-side writes are locked out during a swap; operand port beats IP port
  assign usr_we  = wr_en && !busy;
  assign ip_take = ip_we && !busy && !(usr_we && wr_idx == '0);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [DATA_W-1:0] nxt;
    always_comb begin
      nxt = words[w];
      if (ld_en && ld_idx == IDX_W'(w))       nxt = ld_data;
      else if (usr_we && wr_idx == IDX_W'(w)) nxt = wr_data;
      else if (w == 0 && ip_take)             nxt = ip_wdata;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) words[w] <= '0;
      else        words[w] <= nxt;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (usr_we && wr_idx == rd_idx[p])          rd_data[p] = wr_data;
      else if (ip_take && rd_idx[p] == '0)        rd_data[p] = ip_wdata;
      else                                        rd_data[p] = words[rd_idx[p]];
    end
  end

  assign ip_q    = words[0];
  assign sv_data = words[sv_idx];

  // R6
  ip_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(ld_en && ld_idx == '0) |=> $stable(ip_q));

  // R9
  wr_beats_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ld_en && wr_en && wr_idx == '0 && ip_we |=> ip_q == $past(wr_data));
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int NWORDS = 32,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int ALIGN = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic              busy,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  output logic [IDX_W-1:0]  xfer_idx,
  output logic              ld_en
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  phase_t            phase;
  logic [IDX_W-1:0]  cnt;
  logic [ADDR_W-1:0] old_q;
  logic              done;

  assign busy      = (phase != PH_IDLE);
  assign mem_valid = busy;
  assign mem_write = (phase == PH_SAVE);
  assign mem_addr  = (mem_write ? old_q : base_q) + (ADDR_W'(cnt) << ALIGN);
  assign xfer_idx  = cnt;
  assign ld_en     = (phase == PH_LOAD) && mem_ready;
  assign done      = mem_ready && cnt == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_LOAD;
      cnt    <= '0;
      base_q <= '0;
      old_q  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (base_we) begin
          old_q  <= base_q;
          base_q <= {base_wdata[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
          cnt    <= '0;
          phase  <= PH_SAVE;
        end
        PH_SAVE: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (done) phase <= PH_LOAD;
        end
        PH_LOAD: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (done) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && cnt != LAST |=>
      mem_addr == $past(mem_addr) + ADDR_W'(DATA_W / 8));

  // R4
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[ALIGN-1:0] == '0);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_write && cnt == LAST |=> !busy);
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWORDS = 32,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ip_out,
  input  logic              ip_we,
  input  logic [DATA_W-1:0] ip_wdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_out,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [1:0][IDX_W-1:0]  rd_idx;
  logic [1:0][DATA_W-1:0] rd_data;
  logic [IDX_W-1:0]       xfer_idx;
  logic                   ld_en;

  assign rd_idx   = {rd1_idx, rd0_idx};
  assign rd0_data = rd_data[0];
  assign rd1_data = rd_data[1];

  regwin_seq #(.NWORDS(NWORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_wdata(base_wdata), .base_q(base_out),
    .busy(busy), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_ready(mem_ready),
    .xfer_idx(xfer_idx), .ld_en(ld_en)
  );

  regwin_bank #(.NWORDS(NWORDS), .DATA_W(DATA_W), .NRD(2)) i_bank (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ip_we(ip_we), .ip_wdata(ip_wdata), .ip_q(ip_out),
    .ld_en(ld_en), .ld_idx(xfer_idx), .ld_data(mem_rdata),
    .sv_idx(xfer_idx), .sv_data(mem_wdata)
  );

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
endmodule

// File: tb/test_regwin_ctrl.sv
`timescale 1ns/1ps
module test_regwin_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
  logic [63:0] rd0_data, rd1_data, wr_data = '0, ip_out, ip_wdata = '0;
  logic [63:0] base_wdata = '0, base_out, mem_addr, mem_wdata, mem_rdata;
  logic        wr_en = 1'b0, ip_we = 1'b0, base_we = 1'b0;
  logic        busy, mem_valid, mem_write, mem_ready = 1'b0;

  always #2 clk = ~clk;

  regwin_ctrl i_regwin_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ip_out(ip_out), .ip_we(ip_we), .ip_wdata(ip_wdata),
    .base_we(base_we), .base_wdata(base_wdata), .base_out(base_out), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;

  logic [63:0] mem   [256];
  logic [63:0] model [32];
  logic [63:0] snap  [32];
  logic [63:0] x_old, x_new;
  logic        x_save;
  int          xn;

  function automatic logic [63:0] init_word(int i);
    return {8'h5A, 24'(i * 7 + 3), 32'(i) ^ 32'hC0DE_0000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  assign mem_rdata = mem[mem_addr[10:3]];

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  // memory model plus transfer-order monitor (R1, R3)
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      logic ew;
      int   off;
      ew  = x_save && xn < 32;
      off = ew ? xn : (x_save ? xn - 32 : xn);
      chk(x_save ? "R3 direction" : "R1 direction", 64'(mem_write), 64'(ew));
      chk(x_save ? "R3 address" : "R1 address", mem_addr,
          (ew ? x_old : x_new) + 64'(off * 8));
      if (ew) begin
        chk("R3 save data", mem_wdata, snap[off]);
        mem[mem_addr[10:3]] <= mem_wdata;
      end
      xn <= xn + 1;
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_window(input string tag);
    for (int i = 0; i < 32; i++) begin
      rd0_idx = 5'(i);
      rd1_idx = 5'(31 - i);
      #1;
      chk(tag, rd0_data, mem[8'((x_new >> 3) + 64'(i))]);
      chk(tag, rd1_data, mem[8'((x_new >> 3) + 64'(31 - i))]);
    end
    for (int i = 0; i < 32; i++) model[i] = mem[8'((x_new >> 3) + 64'(i))];
    chk("R8 ip_out after load", ip_out, model[0]);
  endtask

  function automatic logic [63:0] fwd(logic [4:0] idx);
    if (wr_en && wr_idx == idx) return wr_data;
    if (ip_we && idx == 0 && !(wr_en && wr_idx == 0)) return ip_wdata;
    return model[idx];
  endfunction

  task automatic run_random(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk("R8 ip_out", ip_out, model[0]);
      wr_en    = ($urandom % 2) == 1;
      wr_idx   = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
      wr_data  = {$urandom, $urandom};
      ip_we    = ($urandom % 3) == 0;
      ip_wdata = {$urandom, $urandom};
      rd0_idx  = ($urandom % 3 == 0) ? wr_idx : 5'($urandom);
      rd1_idx  = ($urandom % 3 == 0) ? 5'd0 : 5'($urandom);
      #1;
      chk("R7 rd0", rd0_data, fwd(rd0_idx));
      chk("R7 rd1", rd1_data, fwd(rd1_idx));
      chk("R10 no memory traffic", 64'(mem_valid), 64'd0);
      if (wr_en) model[wr_idx] = wr_data;
      if (ip_we && !(wr_en && wr_idx == 0)) model[0] = ip_wdata;
    end
    @(negedge clk);
    wr_en = 0; ip_we = 0;
  endtask

  task automatic do_swap(input logic [63:0] nb);
    @(negedge clk);
    for (int i = 0; i < 32; i++) snap[i] = model[i];
    x_old = base_out; x_new = {nb[63:3], 3'b000}; x_save = 1; xn = 0;
    base_we = 1; base_wdata = nb;
    @(negedge clk);
    base_we = 0;
    chk("R5 busy after base write", 64'(busy), 64'd1);
    chk("R4 aligned base", base_out, x_new);
    // junk during swap (R6)
    for (int k = 0; k < 6; k++) begin
      wr_en = 1; wr_idx = 5'($urandom); wr_data = {$urandom, $urandom};
      ip_we = 1; ip_wdata = {$urandom, $urandom};
      base_we = 1; base_wdata = 64'h100;
      @(negedge clk);
    end
    wr_en = 0; ip_we = 0; base_we = 0;
    wait_idle();
    chk("R6 base write ignored while busy", base_out, x_new);
    chk("R3 transfer count", 64'(xn), 64'd64);
    check_window("R2 window after swap");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = init_word(i);
    x_old = 0; x_new = 0; x_save = 0; xn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy after reset", 64'(busy), 64'd1);
    chk("R1 base after reset", base_out, 64'd0);
    wait_idle();
    chk("R1 load-only count", 64'(xn), 64'd32);
    chk("R5 busy low after load", 64'(busy), 64'd0);
    check_window("R2 window after reset");

    // directed forwarding, R7
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd7; wr_data = 64'hDEAD_BEEF_0000_0007;
    rd0_idx = 5'd7; rd1_idx = 5'd8;
    #1;
    chk("R7 same-cycle forward", rd0_data, 64'hDEAD_BEEF_0000_0007);
    chk("R7 other index", rd1_data, model[8]);
    model[7] = wr_data;
    // directed IP update, R8
    @(negedge clk);
    wr_en = 0; ip_we = 1; ip_wdata = 64'h0000_0000_0000_1000;
    @(negedge clk);
    ip_we = 0; rd0_idx = 0; #1;
    chk("R8 ip update", ip_out, 64'h1000);
    chk("R8 ip at index 0", rd0_data, 64'h1000);
    model[0] = 64'h1000;
    // directed conflict, R9
    @(negedge clk);
    wr_en = 1; wr_idx = 0; wr_data = 64'hAAAA_0000_0000_0001;
    ip_we = 1; ip_wdata = 64'hBBBB_0000_0000_0002;
    @(negedge clk);
    wr_en = 0; ip_we = 0;
    chk("R9 operand write wins", ip_out, 64'hAAAA_0000_0000_0001);
    model[0] = 64'hAAAA_0000_0000_0001;

    run_random(300);
    do_swap(64'h0000_0000_0000_0205);
    run_random(200);
    for (int s = 0; s < 4; s++) begin
      do_swap(64'(($urandom % 225) * 8) | 64'($urandom % 8));
      run_random(150);
    end
    do_swap(64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule